// File: doc/BRIEF.md
# Programmable Counter Timebase

This block is a 16-bit up-counter that serves as the shared timebase for a bank of compare/capture units. Each cycle it may advance by one. The source of those advances is chosen from four options: two fixed divisions of the system clock, a pulse from a neighbouring timer, or rising edges on an asynchronous pin. A run bit starts and stops the counter. An idle-gating option freezes it while the processor is idle.

Software reaches the block through a byte-wide register bus with four addresses: a mode register, a control register and the two counter bytes. Writes land on the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`.

There is no streaming data path, so the bus has no handshake: every write is accepted in its cycle. The block keeps two sticky flags: one for counter wrap-around and one fed by a match/capture pulse from outside. Either flag can raise the interrupt request. The watchdog-enable bit is only held and exported.

Top module: `pcat_top`

## Requirements
- R1: Address map: 0 = mode, 1 = control, 2 = counter bits 7..0, 3 = counter bits 15..8.
  - Mode bits: 7 idle gate, 6 watchdog enable, 2..1 source, 0 wrap-interrupt enable.
  - Control bits: 7 wrap flag, 6 run, 4 module flag.
  - Every other bit reads 0 and ignores writes, and all registers reset to 0.
- R2: Source field 00 gives one advance every 12 clocks and 01 one every 4. Source 10 advances on each cycle in which `tmr_ovf_i` is high. Source 11 advances once per rising edge of `ext_clk_i`; after a two-stage synchronizer, a rising edge set up before clock edge k is counted at edge k+2. A write that changes the source restarts the divider, so the first advance after it comes a full 12 or 4 enabled cycles later.
- R3: With idle gate 1 and `idle_i` high, the counter and divider hold. With idle gate 0, `idle_i` has no effect.
- R4: The counter and divider advance only while run is 1. Run changes only on a write to address 1.
- R5: The wrap flag sets when an advance takes the counter from 0xFFFF to 0x0000. A write to address 1 sets or clears it, and nothing else clears it. A hardware set wins over a same-cycle software clear.
- R6: `irq_o` is high when (wrap flag and wrap-interrupt enable) or module flag.
- R7: A high `match_i` sets the module flag on the next edge. Only a write to address 1 clears it, and a same-cycle `match_i` wins over that clear.
- R8: A write to a counter byte loads that byte and overrides an advance in the same cycle.
- R9: `wdog_en_o` equals mode bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| idle_i | input | 1 | Processor idle state |
| tmr_ovf_i | input | 1 | Overflow pulse from another timer |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| match_i | input | 1 | Match/capture pulse from a module |
| irq_o | output | 1 | Interrupt request |
| wdog_en_o | output | 1 | Watchdog enable bit |

## Verification
The counter is tried with each of the four sources under directed timing. Exact divider counts separate a divide-by-12 from a divide-by-4 and from an off-by-one restart after a source change. A pin held high for many cycles shows whether the block counts levels or edges. Timer pulses presented while idle-gated or stopped show whether the gate and the run bit freeze the count. Random phases then mix register writes, idle, pulses, pin toggles at legal rates and match pulses, and compare every read, the interrupt and the watchdog output with a cycle model built from the requirements.

// File: rtl/pcat_pkg.sv
package pcat_pkg;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_CLO  = 2'd2;
  localparam logic [1:0] A_CHI  = 2'd3;

  // mode register bit positions
  localparam int M_IDLE = 7;
  localparam int M_WDOG = 6;
  localparam int M_SRC_HI = 2;
  localparam int M_SRC_LO = 1;
  localparam int M_WIE = 0;

  // control register bit positions
  localparam int C_WRAP = 7;
  localparam int C_RUN = 6;
  localparam int C_MOD = 4;

  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_FAST  = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_PIN   = 2'd3
  } src_sel_t;
endpackage

// File: rtl/pcat_src.sv
module pcat_src
  import pcat_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_t sel,
  input  logic     clr_pre,
  input  logic     en,
  input  logic     tmr_ovf,
  input  logic     ext_clk,
  output logic     tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic [SYNC_STAGES:0] sh_q;
  logic pin_rise;
  logic divided;

  assign divided = (sel == SRC_SLOW) || (sel == SRC_FAST);
  assign lim = (sel == SRC_SLOW) ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr_pre) begin
      pre_q <= '0;
    end else if (en && divided) begin
      pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
    end
  end

  // synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign pin_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  always_comb begin
    unique case (sel)
      SRC_SLOW, SRC_FAST: tick = (pre_q == lim);
      SRC_TIMER:          tick = tmr_ovf;
      default:            tick = pin_rise;
    endcase
  end
endmodule

// File: rtl/pcat_count.sv
module pcat_count
  import pcat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_lo) begin
      cnt_q[BYTE_W-1:0] <= ld_byte;
    end else if (ld_hi) begin
      cnt_q[CNT_W-1:BYTE_W] <= ld_byte;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign wrap = inc && !ld_lo && !ld_hi && (cnt_q == ALL_ONES);
endmodule

// File: rtl/pcat_top.sv
module pcat_top
  import pcat_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       idle_i,
  input  logic       tmr_ovf_i,
  input  logic       ext_clk_i,
  input  logic       match_i,
  output logic       irq_o,
  output logic       wdog_en_o
);
  logic     idle_gate_q, wdog_q, wie_q;
  src_sel_t src_q;
  logic     wrap_flag_q, run_q, mod_flag_q;

  logic mode_wr, ctrl_wr, en, tick, inc, wrap, clr_pre;
  logic [CNT_W-1:0] cnt;

  assign mode_wr = bus_we && (bus_addr == A_MODE);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign clr_pre = mode_wr && (bus_wdata[M_SRC_HI:M_SRC_LO] != src_q);
  assign en      = run_q && !(idle_gate_q && idle_i);
  assign inc     = en && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_gate_q <= 1'b0;
      wdog_q      <= 1'b0;
      src_q       <= SRC_SLOW;
      wie_q       <= 1'b0;
    end else if (mode_wr) begin
      idle_gate_q <= bus_wdata[M_IDLE];
      wdog_q      <= bus_wdata[M_WDOG];
      src_q       <= src_sel_t'(bus_wdata[M_SRC_HI:M_SRC_LO]);
      wie_q       <= bus_wdata[M_WIE];
    end
  end

  // hardware sets take priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_flag_q <= 1'b0;
      run_q       <= 1'b0;
      mod_flag_q  <= 1'b0;
    end else begin
      wrap_flag_q <= wrap | (ctrl_wr ? bus_wdata[C_WRAP] : wrap_flag_q);
      mod_flag_q  <= match_i | (ctrl_wr ? bus_wdata[C_MOD] : mod_flag_q);
      if (ctrl_wr) run_q <= bus_wdata[C_RUN];
    end
  end

  pcat_src #(
    .DIV_SLOW   (DIV_SLOW),
    .DIV_FAST   (DIV_FAST),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (src_q),
    .clr_pre(clr_pre),
    .en     (en),
    .tmr_ovf(tmr_ovf_i),
    .ext_clk(ext_clk_i),
    .tick   (tick)
  );

  pcat_count u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (inc),
    .ld_lo  (bus_we && (bus_addr == A_CLO)),
    .ld_hi  (bus_we && (bus_addr == A_CHI)),
    .ld_byte(bus_wdata),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = {idle_gate_q, wdog_q, 3'b000, src_q, wie_q};
      A_CTRL:  bus_rdata = {wrap_flag_q, run_q, 1'b0, mod_flag_q, 4'b0000};
      A_CLO:   bus_rdata = cnt[BYTE_W-1:0];
      default: bus_rdata = cnt[CNT_W-1:BYTE_W];
    endcase
  end

  assign irq_o     = (wrap_flag_q && wie_q) || mod_flag_q;
  assign wdog_en_o = wdog_q;
endmodule

// File: rtl/pcat_chk.sv
module pcat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic        idle_i,
  input logic        match_i,
  input logic        irq_o,
  input logic        idle_gate_q,
  input logic        run_q,
  input logic        wrap_flag_q,
  input logic        mod_flag_q,
  input logic        wrap,
  input logic [15:0] cnt
);
  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = bus_we && bus_addr[1];
  assign ctrl_wr = bus_we && (bus_addr == 2'd1);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && idle_gate_q && !cnt_wr) |=> $stable(cnt));

  p_run_only_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(run_q));

  p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt));

  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (wrap_flag_q && cnt == 16'h0000));

  p_wrap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag_q && !ctrl_wr) |=> wrap_flag_q);

  p_match_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> (mod_flag_q && irq_o));

  p_mod_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_flag_q && !ctrl_wr) |=> mod_flag_q);
endmodule

bind pcat_top pcat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .idle_i     (idle_i),
  .match_i    (match_i),
  .irq_o      (irq_o),
  .idle_gate_q(idle_gate_q),
  .run_q      (run_q),
  .wrap_flag_q(wrap_flag_q),
  .mod_flag_q (mod_flag_q),
  .wrap       (wrap),
  .cnt        (cnt)
);

// File: tb/test_pcat_top.sv
`timescale 1ns/1ps
module test_pcat_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic idle_i = 1'b0, tmr_ovf_i = 1'b0, ext_clk_i = 1'b0, match_i = 1'b0;
  logic irq_o, wdog_en_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pcat_top i_pcat_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_i(idle_i),
    .tmr_ovf_i(tmr_ovf_i), .ext_clk_i(ext_clk_i), .match_i(match_i),
    .irq_o(irq_o), .wdog_en_o(wdog_en_o)
  );

  // cycle model written from the requirements
  logic m_idle, m_wd, m_ie, m_cf, m_run, m_mf;
  logic [1:0] m_sel;
  logic [15:0] m_cnt;
  logic [2:0] m_s;
  int m_pre;

  always @(posedge clk or negedge rst_n) begin : mdl
    int lim;
    logic en, tk, inc, cwr, wrp, cw, mw;
    if (!rst_n) begin
      m_idle = 0; m_wd = 0; m_ie = 0; m_cf = 0; m_run = 0; m_mf = 0;
      m_sel = 0; m_cnt = 0; m_s = 0; m_pre = 0;
    end else begin
      en  = m_run && !(m_idle && idle_i);
      lim = (m_sel == 2'd0) ? 11 : 3;
      case (m_sel)
        2'd0, 2'd1: tk = (m_pre == lim);
        2'd2:       tk = tmr_ovf_i;
        default:    tk = m_s[1] && !m_s[2];
      endcase
      inc = en && tk;
      cwr = bus_we && bus_addr[1];
      cw  = bus_we && (bus_addr == 2'd1);
      mw  = bus_we && (bus_addr == 2'd0);
      wrp = inc && !cwr && (m_cnt == 16'hFFFF);
      if (mw && bus_wdata[2:1] != m_sel) m_pre = 0;
      else if (en && m_sel < 2'd2) m_pre = (m_pre == lim) ? 0 : m_pre + 1;
      if (bus_we && bus_addr == 2'd2) m_cnt[7:0] = bus_wdata;
      else if (bus_we && bus_addr == 2'd3) m_cnt[15:8] = bus_wdata;
      else if (inc) m_cnt = m_cnt + 16'd1;
      m_cf = wrp | (cw ? bus_wdata[7] : m_cf);
      m_mf = match_i | (cw ? bus_wdata[4] : m_mf);
      if (cw) m_run = bus_wdata[6];
      if (mw) begin
        m_idle = bus_wdata[7]; m_wd = bus_wdata[6];
        m_sel = bus_wdata[2:1]; m_ie = bus_wdata[0];
      end
      m_s = {m_s[1:0], ext_clk_i};
    end
  end

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {m_idle, m_wd, 3'b000, m_sel, m_ie};
      2'd1:    return {m_cf, m_run, 1'b0, m_mf, 4'b0000};
      2'd2:    return m_cnt[7:0];
      default: return m_cnt[15:8];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R1/R2/R5/R7/R8 read vs model", bus_rdata, m_rd(bus_addr));
    chk("R6 irq vs model", {7'd0, irq_o}, {7'd0, (m_cf && m_ie) || m_mf});
    chk("R9 wdog vs model", {7'd0, wdog_en_o}, {7'd0, m_wd});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  initial begin : watchdog
    #4ms;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int ext_age;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_addr = 2'd0; tick(); chk("R1 mode reset", bus_rdata, 8'h00);
    bus_addr = 2'd1; tick(); chk("R1 ctrl reset", bus_rdata, 8'h00);
    chk("R6 irq reset", {7'd0, irq_o}, 8'h00);

    // R2 divide by 12, then switch to divide by 4
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    bus_addr = 2'd2;
    repeat (11) tick();
    chk("R2 div12 not yet", bus_rdata, 8'h00);
    tick(); chk("R2 div12 first", bus_rdata, 8'h01);
    wr(2'd0, 8'h02);
    bus_addr = 2'd2;
    repeat (3) tick();
    chk("R2 div4 restart not yet", bus_rdata, 8'h01);
    tick(); chk("R2 div4 full period", bus_rdata, 8'h02);

    // R5 wrap and R6 irq via timer source
    wr(2'd0, 8'h05);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
    chk("R6 irq from wrap", {7'd0, irq_o}, 8'h01);
    bus_addr = 2'd1; tick(); chk("R5 wrap flag set", bus_rdata, 8'hC0);
    bus_addr = 2'd2; tick(); chk("R5 wrapped to zero", bus_rdata, 8'h00);

    // R7 match beats same-cycle clear
    match_i = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
    tick(); match_i = 1'b0; bus_we = 1'b0;
    tick(); chk("R7 match wins over clear", bus_rdata, 8'h50);
    chk("R6 irq from module flag", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h40); chk("R7 sw clear", bus_rdata, 8'h40);
    chk("R6 irq low", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'hC0); chk("R5 sw set", bus_rdata, 8'hC0);
    wr(2'd0, 8'h04);
    chk("R6 enable off masks wrap", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'h40);

    // R5 hardware set beats same-cycle clear
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    tmr_ovf_i = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
    tick(); tmr_ovf_i = 1'b0; bus_we = 1'b0;
    tick(); chk("R5 hw set wins", bus_rdata, 8'hC0);
    wr(2'd1, 8'h40);

    // R3 idle gating
    wr(2'd0, 8'h84);
    bus_addr = 2'd2; idle_i = 1'b1; tmr_ovf_i = 1'b1;
    repeat (5) tick();
    tmr_ovf_i = 1'b0; idle_i = 1'b0;
    tick(); chk("R3 idle gated holds", bus_rdata, 8'h00);
    wr(2'd0, 8'h04);
    bus_addr = 2'd2; idle_i = 1'b1; tmr_ovf_i = 1'b1;
    repeat (5) tick();
    tmr_ovf_i = 1'b0; idle_i = 1'b0;
    tick(); chk("R3 idle ignored", bus_rdata, 8'h05);

    // R4 stopped counter
    wr(2'd1, 8'h00);
    bus_addr = 2'd2; tmr_ovf_i = 1'b1;
    repeat (4) tick();
    tmr_ovf_i = 1'b0;
    tick(); chk("R4 run off holds", bus_rdata, 8'h05);

    // R8 load overrides advance
    wr(2'd1, 8'h40);
    tmr_ovf_i = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h10;
    tick(); tmr_ovf_i = 1'b0; bus_we = 1'b0;
    tick(); chk("R8 load wins", bus_rdata, 8'h10);

    // R9 and R1 reserved bits
    wr(2'd0, 8'h40);
    chk("R9 wdog set", {7'd0, wdog_en_o}, 8'h01);
    wr(2'd0, 8'hFF); chk("R1 mode reserved", bus_rdata, 8'hC7);
    wr(2'd1, 8'hFF); chk("R1 ctrl reserved", bus_rdata, 8'hD0);
    wr(2'd1, 8'h00);

    // R2 pin source: edge counting with synchronizer latency
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h40);
    bus_addr = 2'd2; ext_clk_i = 1'b1;
    tick(); tick(); chk("R2 pin latency not yet", bus_rdata, 8'h00);
    tick(); chk("R2 pin edge counted", bus_rdata, 8'h01);
    repeat (10) tick(); chk("R2 pin level not counted", bus_rdata, 8'h01);
    ext_clk_i = 1'b0; repeat (8) tick();
    ext_clk_i = 1'b1; repeat (3) tick();
    chk("R2 pin second edge", bus_rdata, 8'h02);

    // random phase
    ext_age = 0;
    for (int i = 0; i < 3000; i++) begin
      bus_we    = ($urandom % 12) == 0;
      bus_addr  = 2'($urandom);
      bus_wdata = 8'($urandom);
      if (bus_we && bus_addr == 2'd1 && ($urandom % 2 == 0)) bus_wdata[6] = 1'b1;
      idle_i    = ($urandom % 4) == 0;
      tmr_ovf_i = ($urandom % 3) == 0;
      match_i   = ($urandom % 64) == 0;
      ext_age++;
      if (ext_age >= 8 && ($urandom % 2 == 0)) begin
        ext_clk_i = ~ext_clk_i;
        ext_age = 0;
      end
      tick();
    end
    bus_we = 1'b0; match_i = 1'b0; tmr_ovf_i = 1'b0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule